// File: doc/BRIEF.md
# Accelerator Launch and Status Register Bank

This block is the register bank a host processor uses to drive a compute core. The host programs two 32-bit arguments, enables or disables the completion interrupt, and requests a start by writing to a trigger register. The bank turns an accepted request into a single-cycle start pulse to the core and drives the argument values to the core continuously. The core reports a busy level and a one-cycle done pulse. The done pulse is latched into a sticky done flag and an interrupt status flag. The host clears the interrupt flag by writing a one to it.

Every register is 64 bits wide, and the registers sit 8 bytes apart. Bits `[2:0]` of the address select no register. Bits `[5:3]` give the slot, and any higher address bit set makes the access unmapped. Reads are combinational from the address, and writes take effect at the clock edge on which `csr_wr` is high.

Top module: `acc_csr_top`

## Requirements
- R1: After reset every register reads zero, `core_start` is 0 and `irq` is 0.
- R2: Offset 0x00 is read-only. Bit 0 reads 1 while `core_busy` is high or a start pulse is being issued, and 0 otherwise. All other bits read 0, and writes to this offset do nothing.
- R3: A write to offset 0x08 with byte enable 0 and data bit 0 both set, while bit 0 of offset 0x00 is 0, makes `core_start` high for exactly one cycle. That cycle begins at the clock edge after the write.
- R4: Such a start write made while bit 0 of offset 0x00 is 1 is dropped. No pulse follows and the done flag is kept.
- R5: Offset 0x10 bit 0 is the interrupt enable. It is readable and writable under byte enable 0, and its other bits read 0.
- R6: A `core_done` pulse sets both the done flag (offset 0x18 bit 1) and the interrupt status (offset 0x18 bit 0). Both are visible from the next clock edge.
- R7: At offset 0x18, writing 1 to bit 0 under byte enable 0 clears the interrupt status. Writing 0 does nothing, and the done bit cannot be written.
- R8: The done flag clears on the clock edge that accepts a start.
- R9: `irq` is high exactly when the interrupt status and the interrupt enable are both 1.
- R10: Offsets 0x20 and 0x28 hold the offset argument and the N argument, in bits 31:0. Each byte is written only when its byte enable (bits 3:0) is set, bits 63:32 read 0 and are never stored, and the values drive `core_offset` and `core_n`.
- R11: Offsets 0x08, 0x30 and 0x38 read zero, and writes to 0x30 and 0x38 change no register.
- R12: When a `core_done` pulse and an interrupt-clear write fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Write strobe |
| csr_addr | input | ADDR_W | Byte address |
| csr_wdata | input | 64 | Write data |
| csr_be | input | 8 | Byte enables |
| csr_rdata | output | 64 | Read data for `csr_addr` |
| core_start | output | 1 | One-cycle start pulse |
| core_offset | output | 32 | Offset argument |
| core_n | output | 32 | N argument |
| core_busy | input | 1 | Core busy level |
| core_done | input | 1 | Core completion pulse |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted start-pulse register shows up at once, as a doubled pulse or a missing pulse on `core_start`. It also shows in the busy bit read in the following cycle. A wrong done or interrupt flag shows on the very next read of offset 0x18, and through `irq` in the same cycle once the interrupt enable is set. Faults in argument storage show on a readback and on `core_offset` or `core_n` one edge after the write that caused them.

// File: rtl/acc_csr_pkg.sv
package acc_csr_pkg;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned BE_W     = DATA_W / 8;
  localparam int unsigned ARG_W    = 32;
  localparam int unsigned ARG_BE_W = ARG_W / 8;
  localparam int unsigned NUM_ARGS = 2;
  localparam int unsigned SLOT_W   = 3;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_BUSY  = 3'd0,
    SLOT_START = 3'd1,
    SLOT_IRQEN = 3'd2,
    SLOT_STAT  = 3'd3,
    SLOT_ARG0  = 3'd4,
    SLOT_ARG1  = 3'd5
  } slot_e;

  // Byte-lane merge for one argument word.
  function automatic logic [ARG_W-1:0] merge_bytes(
    input logic [ARG_W-1:0]    old_val,
    input logic [ARG_W-1:0]    new_val,
    input logic [ARG_BE_W-1:0] be
  );
    logic [ARG_W-1:0] res;
    res = old_val;
    for (int b = 0; b < int'(ARG_BE_W); b++) begin
      if (be[b]) res[b*8 +: 8] = new_val[b*8 +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/acc_csr_decode.sv
module acc_csr_decode
  import acc_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                         wr,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         wbit0,
  input  logic                         be0,
  input  logic [ARG_BE_W-1:0]          arg_be,
  output logic                         hit,
  output logic [SLOT_W-1:0]            slot,
  output logic                         wr_start_req,
  output logic                         wr_irqen,
  output logic                         wr_w1c,
  output logic [NUM_ARGS-1:0]          wr_arg
);
  localparam int unsigned SLOT_LSB = 3;

  logic unused_lo;
  assign unused_lo = ^addr[SLOT_LSB-1:0];

  assign hit  = ((addr >> (SLOT_LSB + SLOT_W)) == '0);
  assign slot = addr[SLOT_LSB +: SLOT_W];

  assign wr_start_req = wr && hit && (slot == SLOT_START) && be0 && wbit0;
  assign wr_irqen     = wr && hit && (slot == SLOT_IRQEN) && be0;
  assign wr_w1c       = wr && hit && (slot == SLOT_STAT)  && be0 && wbit0;

  for (genvar i = 0; i < int'(NUM_ARGS); i++) begin : g_arg_sel
    assign wr_arg[i] = wr && hit && (slot == SLOT_W'(int'(SLOT_ARG0) + i)) && (arg_be != '0);
  end
endmodule

// File: rtl/acc_csr_args.sv
module acc_csr_args
  import acc_csr_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_ARGS-1:0]               wr_arg,
  input  logic [ARG_W-1:0]                  wdata,
  input  logic [ARG_BE_W-1:0]               be,
  output logic [NUM_ARGS-1:0][ARG_W-1:0]    arg_q
);
  for (genvar i = 0; i < int'(NUM_ARGS); i++) begin : g_arg
    always_ff @(posedge clk) begin
      if (!rst_n)         arg_q[i] <= '0;
      else if (wr_arg[i]) arg_q[i] <= merge_bytes(arg_q[i], wdata, be);
    end

    // R10: an argument changes only on a write addressed to it
    a_r10_arg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_arg[i] |=> $stable(arg_q[i]));
  end
endmodule

// File: rtl/acc_csr_ctrl.sv
module acc_csr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_start_req,
  input  logic wr_irqen,
  input  logic irqen_val,
  input  logic wr_w1c,
  input  logic core_busy,
  input  logic core_done,
  output logic core_start,
  output logic busy_flag,
  output logic start_accept,
  output logic done_q,
  output logic irq_stat_q,
  output logic irq_en_q,
  output logic irq
);
  logic start_q;

  assign busy_flag    = core_busy | start_q;
  assign start_accept = wr_start_req & ~busy_flag;
  assign core_start   = start_q;
  assign irq          = irq_stat_q & irq_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q    <= 1'b0;
      done_q     <= 1'b0;
      irq_stat_q <= 1'b0;
      irq_en_q   <= 1'b0;
    end else begin
      start_q <= start_accept;
      if (core_done)         done_q <= 1'b1;
      else if (start_accept) done_q <= 1'b0;
      if (core_done)         irq_stat_q <= 1'b1;
      else if (wr_w1c)       irq_stat_q <= 1'b0;
      if (wr_irqen)          irq_en_q <= irqen_val;
    end
  end

  // R3: the start pulse never lasts longer than one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R4: a start request while the core is busy produces no pulse
  a_r4_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start_req && core_busy) |=> !core_start);
  // R6: done pulse sets both flags
  a_r6_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> (done_q && irq_stat_q));
  // R7: clear without a competing done pulse empties the status
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_w1c && !core_done) |=> !irq_stat_q);
  // R8: accepted start drops done
  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start_accept && !core_done) |=> !done_q);
  // R9: interrupt only with enable set
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en_q && irq_stat_q));
endmodule

// File: rtl/acc_csr_top.sv
module acc_csr_top
  import acc_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [63:0]       csr_wdata,
  input  logic [7:0]        csr_be,
  output logic [63:0]       csr_rdata,
  output logic              core_start,
  output logic [31:0]       core_offset,
  output logic [31:0]       core_n,
  input  logic              core_busy,
  input  logic              core_done,
  output logic              irq
);
  logic                           hit;
  logic [SLOT_W-1:0]              slot;
  logic                           wr_start_req, wr_irqen, wr_w1c;
  logic [NUM_ARGS-1:0]            wr_arg;
  logic [NUM_ARGS-1:0][ARG_W-1:0] arg_q;
  logic                           busy_flag, start_accept, done_q, irq_stat_q, irq_en_q;

  logic unused_hi;
  assign unused_hi = ^{csr_wdata[DATA_W-1:ARG_W], csr_be[BE_W-1:ARG_BE_W], start_accept};

  acc_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr           (csr_wr),
    .addr         (csr_addr),
    .wbit0        (csr_wdata[0]),
    .be0          (csr_be[0]),
    .arg_be       (csr_be[ARG_BE_W-1:0]),
    .hit          (hit),
    .slot         (slot),
    .wr_start_req (wr_start_req),
    .wr_irqen     (wr_irqen),
    .wr_w1c       (wr_w1c),
    .wr_arg       (wr_arg)
  );

  acc_csr_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_start_req (wr_start_req),
    .wr_irqen     (wr_irqen),
    .irqen_val    (csr_wdata[0]),
    .wr_w1c       (wr_w1c),
    .core_busy    (core_busy),
    .core_done    (core_done),
    .core_start   (core_start),
    .busy_flag    (busy_flag),
    .start_accept (start_accept),
    .done_q       (done_q),
    .irq_stat_q   (irq_stat_q),
    .irq_en_q     (irq_en_q),
    .irq          (irq)
  );

  acc_csr_args u_args (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_arg (wr_arg),
    .wdata  (csr_wdata[ARG_W-1:0]),
    .be     (csr_be[ARG_BE_W-1:0]),
    .arg_q  (arg_q)
  );

  assign core_offset = arg_q[0];
  assign core_n      = arg_q[1];

  always_comb begin
    csr_rdata = '0;
    if (hit) begin
      case (slot)
        SLOT_BUSY:  csr_rdata[0]       = busy_flag;
        SLOT_IRQEN: csr_rdata[0]       = irq_en_q;
        SLOT_STAT:  csr_rdata[1:0]     = {done_q, irq_stat_q};
        SLOT_ARG0:  csr_rdata[ARG_W-1:0] = arg_q[0];
        SLOT_ARG1:  csr_rdata[ARG_W-1:0] = arg_q[1];
        default:    csr_rdata          = '0;
      endcase
    end
  end

  // R2: busy bit reflects the core busy input from the same cycle
  a_r2_busy_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (core_busy && hit && slot == SLOT_BUSY) |-> csr_rdata[0]);
  // R10: argument outputs follow a full-word write on the next edge
  a_r10_offset_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_arg[0] && csr_be[3:0] == 4'hF) |=> core_offset == $past(csr_wdata[31:0]));
endmodule

// File: tb/tb_acc_csr_top.sv
module tb_acc_csr_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic [5:0]  csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [7:0]  csr_be = '0;
  logic [63:0] csr_rdata;
  logic        core_start;
  logic [31:0] core_offset, core_n;
  logic        core_busy = 1'b0;
  logic        core_done = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_csr_top #(.ADDR_W(6)) dut (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_be(csr_be), .csr_rdata(csr_rdata),
    .core_start(core_start), .core_offset(core_offset), .core_n(core_n),
    .core_busy(core_busy), .core_done(core_done), .irq(irq)
  );

  // Entry: {op (0 write, 1 read-check), addr, be, data / expected low word}
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 6'h20, 8'h0F, 32'h1234_5678},
    {1'b1, 6'h20, 8'h00, 32'h1234_5678},
    {1'b0, 6'h20, 8'h02, 32'h0000_AB00},
    {1'b1, 6'h20, 8'h00, 32'h1234_AB78},
    {1'b0, 6'h28, 8'h0F, 32'h0000_0040},
    {1'b1, 6'h28, 8'h00, 32'h0000_0040},
    {1'b0, 6'h28, 8'hF0, 32'hFFFF_FFFF},
    {1'b1, 6'h28, 8'h00, 32'h0000_0040},
    {1'b0, 6'h30, 8'hFF, 32'hFFFF_FFFF},
    {1'b1, 6'h30, 8'h00, 32'h0000_0000},
    {1'b1, 6'h20, 8'h00, 32'h1234_AB78},
    {1'b0, 6'h10, 8'h01, 32'h0000_0001},
    {1'b1, 6'h10, 8'h00, 32'h0000_0001},
    {1'b0, 6'h10, 8'h00, 32'h0000_0000},
    {1'b1, 6'h10, 8'h00, 32'h0000_0001},
    {1'b0, 6'h10, 8'h01, 32'h0000_0000},
    {1'b1, 6'h10, 8'h00, 32'h0000_0000},
    {1'b1, 6'h08, 8'h00, 32'h0000_0000},
    {1'b0, 6'h00, 8'hFF, 32'hFFFF_FFFF},
    {1'b1, 6'h00, 8'h00, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [7:0] be);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = {32'hFFFF_FFFF, d}; csr_be = be;
    @(negedge clk);
    csr_wr = 1'b0; csr_be = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [63:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 core_start", {63'd0, core_start}, 64'd0);
    chk("R1 irq", {63'd0, irq}, 64'd0);
    for (int s = 0; s < 6; s++) begin
      rd(6'(s * 8), r);
      chk("R1 register zero", r, 64'd0);
    end

    // Table walk: R5, R10, R11, R2
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][46] == 1'b0) begin
        wr(VEC[i][45:40], VEC[i][31:0], VEC[i][39:32]);
      end else begin
        rd(VEC[i][45:40], r);
        chk("R5/R10/R11/R2 table read", r, {32'd0, VEC[i][31:0]});
      end
    end
    chk("R10 core_offset", {32'd0, core_offset}, 64'h1234_AB78);
    chk("R10 core_n", {32'd0, core_n}, 64'h40);

    // R3: accepted start, one pulse; R2 busy during the pulse
    wr(6'h08, 32'h1, 8'h01);
    chk("R3 pulse high", {63'd0, core_start}, 64'd1);
    rd(6'h00, r);
    chk("R2 busy during pulse", r, 64'd1);
    @(negedge clk);
    chk("R3 pulse one cycle", {63'd0, core_start}, 64'd0);
    rd(6'h00, r);
    chk("R2 idle", r, 64'd0);

    // R3: start bit written without byte enable 0 gives nothing
    wr(6'h08, 32'h1, 8'hFE);
    chk("R3 no pulse without be0", {63'd0, core_start}, 64'd0);

    // R6: done pulse sets both flags
    @(negedge clk); core_done = 1'b1;
    @(negedge clk); core_done = 1'b0;
    rd(6'h18, r);
    chk("R6 done and status", r, 64'd3);
    chk("R9 irq off with enable 0", {63'd0, irq}, 64'd0);
    wr(6'h10, 32'h1, 8'h01);
    chk("R9 irq on", {63'd0, irq}, 64'd1);

    // R4: start while busy ignored, done kept
    core_busy = 1'b1;
    rd(6'h00, r);
    chk("R2 busy level", r, 64'd1);
    wr(6'h08, 32'h1, 8'h01);
    chk("R4 no pulse", {63'd0, core_start}, 64'd0);
    @(negedge clk);
    chk("R4 still no pulse", {63'd0, core_start}, 64'd0);
    rd(6'h18, r);
    chk("R4 done kept", r, 64'd3);
    core_busy = 1'b0;

    // R7: writing zero to status, or trying the done bit
    wr(6'h18, 32'h2, 8'h01);
    rd(6'h18, r);
    chk("R7 write zero no effect", r, 64'd3);
    wr(6'h18, 32'h1, 8'h01);
    rd(6'h18, r);
    chk("R7 w1c clears status only", r, 64'd2);
    chk("R9 irq off after clear", {63'd0, irq}, 64'd0);

    // R8: accepted start clears done
    wr(6'h08, 32'h1, 8'h01);
    rd(6'h18, r);
    chk("R8 done cleared", r, 64'd0);
    chk("R8 pulse issued", {63'd0, core_start}, 64'd1);
    @(negedge clk);

    // R12: done pulse and clear on the same edge
    csr_wr = 1'b1; csr_addr = 6'h18; csr_wdata = 64'h1; csr_be = 8'h01;
    core_done = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0; csr_be = '0; core_done = 1'b0;
    rd(6'h18, r);
    chk("R12 set wins", r, 64'd3);
    chk("R12 irq", {63'd0, irq}, 64'd1);

    // R11: write to 0x38 leaves everything unchanged
    wr(6'h38, 32'h0, 8'hFF);
    rd(6'h38, r);
    chk("R11 0x38 reads zero", r, 64'd0);
    rd(6'h10, r);
    chk("R11 enable untouched", r, 64'd1);
    chk("R11 args untouched", {core_n, core_offset}, {32'h40, 32'h1234_AB78});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule